// File: doc/BRIEF.md
# Memory-Mapped Character Terminal Controller

This block gives a 32-bit processor a character terminal through four word registers on a simple load/store bus. A keyboard source delivers bytes over a valid/ready handshake into a one-character receive holding register. Bytes stored by the processor go out to a display sink over a second valid/ready handshake. Software can poll each direction's Ready flag, or set that direction's Interrupt Enable bit and wait for the level-sensitive interrupt line.

Each direction is a two-state machine. The receiver sits in RX_EMPTY until a keyboard handshake completes (transition *accept*), which moves it to RX_FULL. A processor load from the receive data register (transition *take*) returns it to RX_EMPTY. The transmitter sits in TX_IDLE (Ready = 1) until a store to the transmit data register (transition *launch*), which moves it to TX_SEND. It returns to TX_IDLE once the sink accepts the byte (transition *drain*).

The bus read path is combinational. Register state changes on the rising clock edge that ends the access. Reset is asynchronous and active low.

Top module: `term_mmio_ctrl`

## Requirements
- R1: After reset, receiver Ready is 0, transmitter Ready is 1, both Interrupt Enable bits are 0, irq is 0, kb_ready is 1 and disp_valid is 0.
- R2: The registers decode at word addresses 0xFFFF0000 (receive control), 0xFFFF0004 (receive data), 0xFFFF0008 (transmit control) and 0xFFFF000C (transmit data). Any other address, including 0xFFFF0010, reads as zero, and writes to it have no effect.
- R3: A control register reads Ready in bit 0, Interrupt Enable in bit 1 and zero in bits 31:2.
- R4: When kb_valid and kb_ready are both high at a clock edge, the byte is captured and receiver Ready reads 1 from the next cycle. The receive data register then returns the byte in bits 7:0, with bits 31:8 zero.
- R5: While receiver Ready is 1, kb_ready is low and the held character is not overwritten.
- R6: A load from the receive data register clears receiver Ready at the end of that access. A load from the receive control register leaves it unchanged.
- R7: A store to a control register with byte enable 0 set writes Interrupt Enable from data bit 1. Data bit 0 is ignored. A store with byte enable 0 clear leaves Interrupt Enable unchanged.
- R8: A store to the transmit data register with byte enable 0 set, while transmitter Ready is 1, makes disp_valid high on the next cycle with disp_data equal to the store's bits 7:0. Transmitter Ready reads 0 from that cycle on.
- R9: disp_valid and disp_data stay stable until disp_ready is seen high. After that edge, transmitter Ready reads 1 and disp_valid is low.
- R10: A store to the transmit data register while transmitter Ready is 0 is ignored: no extra byte reaches the sink and disp_data is unchanged.
- R11: irq is high exactly when (receiver Ready and receiver Interrupt Enable) or (transmitter Ready and transmitter Interrupt Enable) holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_be | input | 4 | Byte enables for stores |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data (combinational) |
| kb_valid | input | 1 | Keyboard byte offered |
| kb_data | input | 8 | Keyboard byte |
| kb_ready | output | 1 | Receiver can take a byte |
| disp_valid | output | 1 | Display byte offered |
| disp_data | output | 8 | Display byte |
| disp_ready | input | 1 | Display sink takes the byte |
| irq | output | 1 | Level interrupt request |

## Verification
The receive path is driven with single keystrokes, and with a second keystroke offered while the first is still unread. This separates correct back-pressure from overwriting, and separates a clear on a data load from a clear on a control load. The transmit path is tried with the sink stalled while extra stores arrive, which exposes whether busy-time stores are dropped. It is also tried with a back-to-back burst against an always-ready sink, where a scoreboard compares every byte the sink accepts, in order. Interrupt Enable is toggled with each Ready flag both set and clear, and stores to unmapped addresses and stores with the low byte lane disabled show whether either of them leaks into state.

// File: rtl/term_pkg.sv
package term_pkg;
    typedef enum logic { RX_EMPTY, RX_FULL } rx_state_t;
    typedef enum logic { TX_IDLE, TX_SEND } tx_state_t;
    typedef enum logic [2:0] { REG_RXC, REG_RXD, REG_TXC, REG_TXD, REG_NONE } reg_sel_t;

    localparam int unsigned RDY_BIT = 0;
    localparam int unsigned IE_BIT  = 1;
endpackage

// File: rtl/term_addr_dec.sv
module term_addr_dec
    import term_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int unsigned WIN_LSB = 4;

    logic in_win;
    assign in_win = (addr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]) && (addr[1:0] == 2'b00);

    always_comb begin
        sel = REG_NONE;
        if (in_win) begin
            unique case (addr[3:2])
                2'd0: sel = REG_RXC;
                2'd1: sel = REG_RXD;
                2'd2: sel = REG_TXC;
                2'd3: sel = REG_TXD;
            endcase
        end
    end
endmodule

// File: rtl/term_rx_chan.sv
module term_rx_chan
    import term_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kb_valid,
    input  logic [CHAR_W-1:0] kb_data,
    output logic              kb_ready,
    input  logic              take,
    input  logic              ie_wr,
    input  logic              ie_val,
    output logic              ready,
    output logic              ie,
    output logic [CHAR_W-1:0] hold
);
    rx_state_t state_q, state_d;
    logic accept;

    assign accept = kb_valid && kb_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (accept) state_d = RX_FULL;
            RX_FULL:  if (take)   state_d = RX_EMPTY;
        endcase
    end

    always_comb begin
        kb_ready = 1'b0;
        ready    = 1'b0;
        unique case (state_q)
            RX_EMPTY: kb_ready = 1'b1;
            RX_FULL:  ready    = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= '0;
            ie   <= 1'b0;
        end else begin
            if (accept) hold <= kb_data;
            if (ie_wr)  ie   <= ie_val;
        end
    end

    // R4
    rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (ready && hold == $past(kb_data)));
    // R5
    rx_no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !take) |=> (ready && $stable(hold)));
    // R6
    rx_take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && take) |=> !ready);
endmodule

// File: rtl/term_tx_chan.sv
module term_tx_chan
    import term_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_req,
    input  logic [CHAR_W-1:0] launch_char,
    input  logic              ie_wr,
    input  logic              ie_val,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_data,
    input  logic              disp_ready,
    output logic              ready,
    output logic              ie
);
    tx_state_t state_q, state_d;
    logic launch;

    assign launch = launch_req && (state_q == TX_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (launch)     state_d = TX_SEND;
            TX_SEND: if (disp_ready) state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        ready      = 1'b0;
        disp_valid = 1'b0;
        unique case (state_q)
            TX_IDLE: ready      = 1'b1;
            TX_SEND: disp_valid = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_data <= '0;
            ie        <= 1'b0;
        end else begin
            if (launch) disp_data <= launch_char;
            if (ie_wr)  ie        <= ie_val;
        end
    end

    // R8
    tx_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_req && ready) |=> (disp_valid && disp_data == $past(launch_char)));
    // R9
    tx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_data)));
    // R9
    tx_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=> (ready && !disp_valid));
    // R10
    tx_busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && launch_req) |=> $stable(disp_data));
endmodule

// File: rtl/term_mmio_ctrl.sv
module term_mmio_ctrl
    import term_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CHAR_W = 8,
    parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                kb_valid,
    input  logic [CHAR_W-1:0]   kb_data,
    output logic                kb_ready,
    output logic                disp_valid,
    output logic [CHAR_W-1:0]   disp_data,
    input  logic                disp_ready,
    output logic                irq
);
    reg_sel_t sel;
    logic rd, wr, lane0;
    logic rx_ready, rx_ie, tx_ready, tx_ie;
    logic [CHAR_W-1:0] rx_hold;

    term_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign rd    = bus_sel && !bus_we;
    assign wr    = bus_sel &&  bus_we;
    assign lane0 = bus_be[0];

    term_rx_chan #(.CHAR_W(CHAR_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .kb_valid (kb_valid),
        .kb_data  (kb_data),
        .kb_ready (kb_ready),
        .take     (rd && sel == REG_RXD),
        .ie_wr    (wr && lane0 && sel == REG_RXC),
        .ie_val   (bus_wdata[IE_BIT]),
        .ready    (rx_ready),
        .ie       (rx_ie),
        .hold     (rx_hold)
    );

    term_tx_chan #(.CHAR_W(CHAR_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_req  (wr && lane0 && sel == REG_TXD),
        .launch_char (bus_wdata[CHAR_W-1:0]),
        .ie_wr       (wr && lane0 && sel == REG_TXC),
        .ie_val      (bus_wdata[IE_BIT]),
        .disp_valid  (disp_valid),
        .disp_data   (disp_data),
        .disp_ready  (disp_ready),
        .ready       (tx_ready),
        .ie          (tx_ie)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            unique case (sel)
                REG_RXC: begin
                    bus_rdata[RDY_BIT] = rx_ready;
                    bus_rdata[IE_BIT]  = rx_ie;
                end
                REG_RXD: bus_rdata[CHAR_W-1:0] = rx_hold;
                REG_TXC: begin
                    bus_rdata[RDY_BIT] = tx_ready;
                    bus_rdata[IE_BIT]  = tx_ie;
                end
                REG_TXD, REG_NONE: bus_rdata = '0;
            endcase
        end
    end

    assign irq = (rx_ready && rx_ie) || (tx_ready && tx_ie);

    // R3
    ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (sel == REG_RXC || sel == REG_TXC)) |-> (bus_rdata[DATA_W-1:2] == '0));
    // R2
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == REG_NONE) |-> (bus_rdata == '0));
    // R11
    irq_rx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_valid && kb_ready && rx_ie && !(wr && sel == REG_RXC)) |=> irq);
endmodule

// File: tb/term_mmio_ctrl_test.sv
module term_mmio_ctrl_test;
    localparam logic [31:0] RXC = 32'hFFFF_0000;
    localparam logic [31:0] RXD = 32'hFFFF_0004;
    localparam logic [31:0] TXC = 32'hFFFF_0008;
    localparam logic [31:0] TXD = 32'hFFFF_000C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0] bus_be = '0;
    logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic kb_valid = 1'b0, kb_ready;
    logic [7:0] kb_data = '0;
    logic disp_valid, disp_ready = 1'b0, irq;
    logic [7:0] disp_data;

    int n_chk = 0, n_err = 0, pops = 0, pushes = 0;
    bit done = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    term_mmio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_be(bus_be),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kb_valid(kb_valid), .kb_data(kb_data), .kb_ready(kb_ready),
        .disp_valid(disp_valid), .disp_data(disp_data), .disp_ready(disp_ready), .irq(irq)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; bus_be = '0;
    endtask

    task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic kb_push(input logic [7:0] b);
        @(negedge clk);
        kb_valid = 1; kb_data = b;
        @(negedge clk);
        kb_valid = 0;
    endtask

    // driver: a store that should be accepted also enters the scoreboard
    task automatic tx_send(input logic [7:0] b);
        exp_q.push_back(b);
        pushes++;
        bus_wr(TXD, {24'hA5A5A5, b}, 4'hF);
    endtask

    // monitor: compare each byte the sink takes
    always begin
        @(negedge clk);
        #2;
        if (rst_n && disp_valid && disp_ready) begin
            pops++;
            if (exp_q.size() == 0) chk("R10 unexpected byte", {24'd0, disp_data}, 32'hXX);
            else chk("R8 sink byte", {24'd0, disp_data}, {24'd0, exp_q.pop_front()});
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 kb_ready", {31'd0, kb_ready}, 1);
        chk("R1 disp_valid", {31'd0, disp_valid}, 0);
        bus_rd(RXC, d); chk("R1 R3 rx ctrl", d, 32'h0);
        bus_rd(TXC, d); chk("R1 R3 tx ctrl", d, 32'h1);

        // R4 capture, R6 clear on data load only
        kb_push(8'h41);
        bus_rd(RXC, d); chk("R4 rx ready", d, 32'h1);
        bus_rd(RXC, d); chk("R6 ctrl load keeps ready", d, 32'h1);
        bus_rd(RXD, d); chk("R4 rx data", d, 32'h41);
        bus_rd(RXC, d); chk("R6 ready cleared", d, 32'h0);

        // R5 back-pressure while unread
        kb_push(8'h52);
        @(negedge clk); kb_valid = 1; kb_data = 8'h53;
        #2 chk("R5 kb_ready low", {31'd0, kb_ready}, 0);
        repeat (3) @(negedge clk);
        bus_rd(RXD, d); chk("R5 held byte kept", d, 32'h52);
        @(negedge clk); kb_valid = 0;
        bus_rd(RXD, d); chk("R5 second byte after take", d, 32'h53);

        // R7 IE write, Ready bit ignored, lane gating
        bus_wr(RXC, 32'h3, 4'hF);
        bus_rd(RXC, d); chk("R7 rx ie set ready ignored", d, 32'h2);
        bus_wr(RXC, 32'h0, 4'hE);
        bus_rd(RXC, d); chk("R7 lane0 off keeps ie", d, 32'h2);
        #2 chk("R11 irq idle rx empty", {31'd0, irq}, 0);
        kb_push(8'h7A);
        #2 chk("R11 irq rx ready+ie", {31'd0, irq}, 1);
        bus_rd(RXD, d); chk("R4 rx data 7A", d, 32'h7A);
        #2 chk("R11 irq after take", {31'd0, irq}, 0);

        // R2 unmapped
        bus_wr(32'hFFFF_0010, 32'h0, 4'hF);
        bus_wr(32'h0000_0000, 32'h0, 4'hF);
        bus_rd(RXC, d); chk("R2 unmapped write no effect", d, 32'h2);
        bus_rd(32'hFFFF_0010, d); chk("R2 unmapped read", d, 32'h0);
        bus_rd(32'h0000_0008, d); chk("R2 other page read", d, 32'h0);
        bus_rd(TXD, d); chk("R2 tx data reads zero", d, 32'h0);

        // R8 R9 R10 transmit with stalled sink
        disp_ready = 0;
        tx_send(8'h48);
        #2 chk("R8 disp_valid", {31'd0, disp_valid}, 1);
        chk("R8 disp_data", {24'd0, disp_data}, 32'h48);
        bus_rd(TXC, d); chk("R8 tx busy", d, 32'h0);
        bus_wr(TXD, 32'h99, 4'hF);
        #2 chk("R10 busy store ignored", {24'd0, disp_data}, 32'h48);
        bus_wr(TXC, 32'h2, 4'hF);
        #2 chk("R11 irq tx busy", {31'd0, irq}, 0);
        @(negedge clk); disp_ready = 1;
        @(negedge clk); #2;
        chk("R9 valid drops", {31'd0, disp_valid}, 0);
        chk("R11 irq tx ready+ie", {31'd0, irq}, 1);
        bus_rd(TXC, d); chk("R9 tx ready back", d, 32'h3);

        // burst with polling
        for (int i = 0; i < 6; i++) begin
            do bus_rd(TXC, d); while (d[0] == 1'b0);
            tx_send(8'h60 + 8'(i));
        end
        repeat (4) @(negedge clk);
        #3;
        chk("R9 all bytes drained", pops, pushes);
        chk("R10 scoreboard empty", exp_q.size(), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule